// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous static RAM that accepts a read or a write command on every clock. There is no turnaround penalty: reads and writes can follow each other on consecutive edges with no idle cycle between them. The write data does not travel with its command. It follows one edge later in flow-through mode and two edges later in pipelined mode. The `flow` input chooses the mode, and both `flow` and `ilv` are meant to be held static.

Each command is either a load or an advance. A load starts a four-beat burst at the address presented. An advance steps to the next beat of the current burst and reuses that burst's direction. The beat order is either linear or interleaved. Writes update 9-bit byte lanes under per-lane enables. When a read targets a location whose write data has not yet landed in the array, the read returns the newer data, with the byte mask applied. Output enable and sleep gate the output drive asynchronously.

Top module: `sram_nbt_core`

## Requirements
- R1: While reset is held and after it is released, `dout_en` is 0 and `dout` is all zeros until a read is due.
- R2: With `flow`=1, read data for a command sampled at edge N is on `dout` after edge N. For a write sampled at edge N, `din` is sampled at edge N+1.
- R3: With `flow`=0, read data for a command sampled at edge N appears after edge N+1. For a write sampled at edge N, `din` is sampled at edge N+2.
- R4: Reads and writes issued on consecutive edges in any order all complete correctly. A read returns the data of every earlier write, including a write whose data is still in flight.
- R5: `bwe[i]`=1 writes bits [9i+8:9i] of `din`. Lane 0 is bits 8:0 and lane 1 is bits 17:9. A lane whose bit is 0 keeps its old value.
- R6: A load (`adv`=0) is accepted only when all three bits of `ce` are 1. Any other `ce` value is a deselect. A deselect ends the current burst, so a later advance does nothing.
- R7: An advance (`adv`=1) moves to the next beat of the active burst and keeps that burst's read/write direction. It ignores `ce` and `we`.
- R8: With `ilv`=0, beat k (k=0..3) uses address bits [1:0] = (start + k) mod 4. The upper bits stay those of the load address.
- R9: With `ilv`=1, beat k uses address bits [1:0] = start XOR k.
- R10: With `oe`=0, `dout_en` is 0 and `dout` is zero at once, without waiting for a clock edge.
- R11: With `sleep`=1, new commands are ignored, the array contents are kept, and `dout_en` is 0 at once. Data for writes already accepted still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| addr | input | ADDR_W | Word address for a load |
| adv | input | 1 | 1 = advance the burst, 0 = load a new command |
| we | input | 1 | 1 = write, 0 = read (load cycles only) |
| bwe | input | NBYTES | Byte-lane write enables, sampled with the command |
| ce | input | 3 | Chip enables; all must be 1 to accept a load |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Power-down: blocks commands, turns off outputs |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| flow | input | 1 | 1 = flow-through, 0 = pipelined |
| din | input | NBYTES*BYTE_W | Late write data |
| dout | output | NBYTES*BYTE_W | Read data; zero while not driven |
| dout_en | output | 1 | Output drive enable |

## Verification
In flow-through mode a read is due on the same edge that captures it, and its write data is sampled one edge after the command. In pipelined mode the read is due one edge later and the write data two edges later. For each command the bench records, in a slot indexed by edge number, the edge at which its data must be driven or its result must appear. It drives inputs and samples outputs at the falling edge. After every rising edge it compares `dout_en` and `dout` with that edge's slot, so an early or late result counts as a miscompare. The output-enable and sleep gates are also probed a few nanoseconds after the level change, with no clock edge in between.

// File: rtl/sram_nbt_pkg.sv
package sram_nbt_pkg;

    localparam int BEAT_W = 2;

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
    } burst_t;

    // beat address low bits: interleaved xor, linear modulo add
    function automatic logic [BEAT_W-1:0] burst_low(input logic [BEAT_W-1:0] s,
                                                    input logic [BEAT_W-1:0] k,
                                                    input logic              ilv);
        return ilv ? (s ^ k) : (s + k);
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
    import sram_nbt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              ilv,
    input  logic              adv,
    input  logic              we,
    input  logic [2:0]        ce,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam int BASE_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        burst_t            b;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = {seq_q.base, seq_q.b.start};
        if (!sleep) begin
            if (adv) begin
                if (seq_q.b.act) begin
                    seq_d.b.beat = seq_q.b.beat + 1'b1;
                    cmd_valid    = 1'b1;
                    cmd_we       = seq_q.b.wr;
                    cmd_addr     = {seq_q.base, burst_low(seq_q.b.start, seq_d.b.beat, ilv)};
                end
            end else if (&ce) begin
                seq_d.base    = addr[ADDR_W-1:BEAT_W];
                seq_d.b.act   = 1'b1;
                seq_d.b.wr    = we;
                seq_d.b.start = addr[BEAT_W-1:0];
                seq_d.b.beat  = '0;
                cmd_valid     = 1'b1;
                cmd_we        = we;
                cmd_addr      = addr;
            end else begin
                seq_d.b.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R6
    desel_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adv && !(&ce)) |=> !seq_q.b.act);

    // R11
    sleep_holds_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> $stable(seq_q));

endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_mask,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    // one storage column per byte lane so each lane writes on its own enable
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) cells[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/sram_nbt_core.sv
module sram_nbt_core
    import sram_nbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     adv,
    input  logic                     we,
    input  logic [NBYTES-1:0]        bwe,
    input  logic [2:0]               ce,
    input  logic                     oe,
    input  logic                     sleep,
    input  logic                     ilv,
    input  logic                     flow,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_en
);
    localparam int DATA_W = NBYTES * BYTE_W;

    typedef struct packed {
        logic              w1_v;
        logic [ADDR_W-1:0] w1_a;
        logic [NBYTES-1:0] w1_m;
        logic              w2_v;
        logic [ADDR_W-1:0] w2_a;
        logic [NBYTES-1:0] w2_m;
        logic              r1_v;
        logic [ADDR_W-1:0] r1_a;
        logic              o_v;
        logic [DATA_W-1:0] o_d;
    } pipe_t;

    pipe_t             st_d, st_q;
    logic              cmd_valid, cmd_we;
    logic [ADDR_W-1:0] cmd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NBYTES-1:0] wr_mask;
    logic [DATA_W-1:0] rd_data, fwd_data;
    logic              fwd_hit, vis_v;
    logic [DATA_W-1:0] vis_d;

    sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ilv(ilv), .adv(adv), .we(we),
        .ce(ce), .addr(addr), .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr)
    );

    // flow-through commits one edge after the command, pipelined two
    assign wr_en   = flow ? st_q.w1_v : st_q.w2_v;
    assign wr_addr = flow ? st_q.w1_a : st_q.w2_a;
    assign wr_mask = flow ? st_q.w1_m : st_q.w2_m;

    sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(din),
        .rd_addr(st_q.r1_a), .rd_data(rd_data)
    );

    // pipelined only: the write one edge ahead of the read lands at the capture edge
    assign fwd_hit = !flow && st_q.w2_v && (st_q.w2_a == st_q.r1_a);

    for (genvar g = 0; g < NBYTES; g++) begin : g_fwd
        assign fwd_data[g*BYTE_W +: BYTE_W] = (fwd_hit && st_q.w2_m[g]) ?
            din[g*BYTE_W +: BYTE_W] : rd_data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d      = st_q;
        st_d.w1_v = cmd_valid && cmd_we;
        st_d.w1_a = cmd_addr;
        st_d.w1_m = bwe;
        st_d.w2_v = st_q.w1_v;
        st_d.w2_a = st_q.w1_a;
        st_d.w2_m = st_q.w1_m;
        st_d.r1_v = cmd_valid && !cmd_we;
        st_d.r1_a = cmd_addr;
        st_d.o_v  = st_q.r1_v;
        st_d.o_d  = fwd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vis_v   = flow ? st_q.r1_v : st_q.o_v;
    assign vis_d   = flow ? rd_data   : st_q.o_d;
    assign dout_en = oe && !sleep && vis_v;
    assign dout    = dout_en ? vis_d : '0;

    // R2
    flow_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flow && cmd_valid && cmd_we) |=> wr_en);

    // R3
    pipe_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow && cmd_valid && cmd_we) |-> ##2 wr_en);

    // R3
    pipe_read_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow && cmd_valid && !cmd_we) |-> ##2 st_q.o_v);

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!dout_en && dout == '0));

endmodule

// File: tb/sim_sram_nbt_core.sv
module sim_sram_nbt_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        adv = 1'b0, we = 1'b0, oe = 1'b1, slp = 1'b0, ilv = 1'b0, flow = 1'b0;
    logic [1:0]  bwe = '0;
    logic [2:0]  ce = '0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_en;

    int n_chk = 0, n_bad = 0, e = 0;
    bit done = 0;
    logic [17:0] ref_mem [64];
    logic [17:0] ds [8];
    logic [17:0] ed [8];
    bit          ev [8];
    int bbase = 0, bs = 0, bc = 0;
    bit bwr = 0, bact = 0;
    logic [2:0] ce_off = 3'b101;

    sram_nbt_core u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .we(we), .bwe(bwe), .ce(ce),
        .oe(oe), .sleep(slp), .ilv(ilv), .flow(flow), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic got_en, input logic [17:0] got_d,
                         input logic exp_en, input logic [17:0] exp_d);
        n_chk++;
        if (got_en !== exp_en || got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s: actual en=%0b d=%h, expected en=%0b d=%h",
                     tag, got_en, got_d, exp_en, exp_d);
        end
    endtask

    // one clock: drive at falling edge, model the command, compare after the rising edge
    task automatic cyc(input string tag, input bit sel, input bit advc, input bit wr,
                       input int a, input logic [1:0] be, input logic [17:0] wd);
        int lw = flow ? 1 : 2;
        int lr = flow ? 0 : 1;
        bit acc = 0;
        int ea = 0;
        bit xe;
        logic [17:0] xd;
        ce = sel ? 3'b111 : ce_off;
        adv = advc; we = wr; addr = 6'(a); bwe = be;
        din = ds[e % 8];
        if (!slp) begin
            if (advc) begin
                if (bact) begin
                    bc = (bc + 1) & 3;
                    acc = 1;
                    ea = bbase * 4 + (ilv ? (bs ^ bc) : ((bs + bc) & 3));
                end
            end else if (sel) begin
                bbase = a / 4; bs = a % 4; bc = 0; bwr = wr; bact = 1; acc = 1; ea = a;
            end else begin
                bact = 0;
            end
        end
        if (acc && bwr) begin
            for (int i = 0; i < 2; i++)
                if (be[i]) ref_mem[ea][i*9 +: 9] = wd[i*9 +: 9];
            ds[(e + lw) % 8] = wd;
        end
        if (acc && !bwr) begin
            ev[(e + lr) % 8] = 1;
            ed[(e + lr) % 8] = ref_mem[ea];
        end
        @(posedge clk);
        @(negedge clk);
        xe = ev[e % 8] && oe && !slp;
        xd = xe ? ed[e % 8] : 18'h0;
        check(tag, dout_en, dout, xe, xd);
        ev[e % 8] = 0;
        ds[e % 8] = '0;
        e++;
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 2'b00, 18'h0);
    endtask

    task automatic do_reset(input bit fl, input bit il);
        @(negedge clk);
        rst_n = 0; flow = fl; ilv = il; ce = '0; adv = 0; we = 0; din = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 outputs quiet during reset
        check("R1", dout_en, dout, 1'b0, 18'h0);
        rst_n = 1;
        for (int i = 0; i < 8; i++) begin ev[i] = 0; ds[i] = '0; end
        bact = 0; e = 0;
        @(negedge clk);
        check("R1", dout_en, dout, 1'b0, 18'h0);
    endtask

    task automatic t_flow();
        do_reset(1, 0);
        cyc("R2", 1, 0, 1, 8, 2'b11, 18'h11111);
        cyc("R7", 0, 1, 0, 0, 2'b11, 18'h12222);
        cyc("R8", 1, 1, 0, 0, 2'b11, 18'h13333);
        cyc("R8", 1, 1, 0, 0, 2'b11, 18'h14444);
        cyc("R2", 1, 0, 0, 10, 2'b00, 18'h0);
        cyc("R8", 1, 1, 1, 0, 2'b00, 18'h0);
        cyc("R8", 1, 1, 0, 0, 2'b00, 18'h0);
        cyc("R8", 1, 1, 0, 0, 2'b00, 18'h0);
        cyc("R2", 1, 0, 1, 12, 2'b11, 18'h2F0F0);
        cyc("R2", 1, 0, 0, 12, 2'b00, 18'h0);
        idle("R2", 3);
    endtask

    task automatic t_pipe();
        do_reset(0, 0);
        cyc("R3", 1, 0, 1, 16, 2'b11, 18'h2AAAA);
        cyc("R4", 1, 0, 0, 16, 2'b00, 18'h0);
        cyc("R4", 1, 0, 1, 16, 2'b01, 18'h00055);
        cyc("R4", 1, 0, 0, 16, 2'b00, 18'h0);
        cyc("R4", 1, 0, 1, 17, 2'b11, 18'h01234);
        cyc("R4", 1, 0, 0, 17, 2'b00, 18'h0);
        cyc("R4", 1, 0, 0, 16, 2'b00, 18'h0);
        cyc("R4", 1, 0, 1, 17, 2'b10, 18'h3FE00);
        cyc("R4", 1, 0, 0, 17, 2'b00, 18'h0);
        idle("R3", 3);
    endtask

    task automatic t_bytes();
        cyc("R5", 1, 0, 1, 20, 2'b11, 18'h1FF00);
        cyc("R5", 1, 0, 1, 20, 2'b10, 18'h3C0C3);
        idle("R5", 2);
        cyc("R5", 1, 0, 0, 20, 2'b00, 18'h0);
        cyc("R5", 1, 0, 1, 20, 2'b00, 18'h15555);
        idle("R5", 2);
        cyc("R5", 1, 0, 0, 20, 2'b00, 18'h0);
        idle("R5", 3);
    endtask

    task automatic t_ilv();
        do_reset(0, 1);
        cyc("R9", 1, 0, 1, 33, 2'b11, 18'h0A001);
        cyc("R9", 1, 1, 0, 0, 2'b11, 18'h0B002);
        cyc("R9", 1, 1, 0, 0, 2'b11, 18'h0C003);
        cyc("R9", 1, 1, 0, 0, 2'b11, 18'h0D004);
        idle("R9", 3);
        for (int a = 32; a < 36; a++) cyc("R9", 1, 0, 0, a, 2'b00, 18'h0);
        cyc("R9", 1, 0, 0, 34, 2'b00, 18'h0);
        for (int i = 0; i < 3; i++) cyc("R9", 1, 1, 0, 0, 2'b00, 18'h0);
        idle("R9", 3);
    endtask

    task automatic t_desel();
        cyc("R6", 1, 0, 1, 40, 2'b11, 18'h2468A);
        idle("R6", 3);
        ce_off = 3'b011;
        cyc("R6", 0, 0, 1, 40, 2'b11, 18'h3FFFF);
        ce_off = 3'b110;
        cyc("R6", 0, 1, 1, 40, 2'b11, 18'h3FFFF);
        ce_off = 3'b101;
        cyc("R6", 0, 1, 1, 41, 2'b11, 18'h3FFFF);
        idle("R6", 3);
        cyc("R6", 1, 0, 0, 40, 2'b00, 18'h0);
        cyc("R7", 0, 1, 1, 0, 2'b11, 18'h0);
        idle("R6", 2);
    endtask

    task automatic t_oe();
        oe = 0;
        cyc("R10", 1, 0, 0, 40, 2'b00, 18'h0);
        idle("R10", 1);
        oe = 1;
        cyc("R10", 1, 0, 0, 40, 2'b00, 18'h0);
        idle("R10", 1);
        #2 oe = 0;
        #1 check("R10", dout_en, dout, 1'b0, 18'h0);
        oe = 1;
        #1 check("R10", dout_en, dout, 1'b1, ref_mem[40]);
        idle("R10", 2);
    endtask

    task automatic t_sleep();
        slp = 1;
        cyc("R11", 1, 0, 1, 40, 2'b11, 18'h3FFFF);
        cyc("R11", 1, 0, 0, 40, 2'b00, 18'h0);
        idle("R11", 3);
        slp = 0;
        cyc("R11", 1, 0, 0, 40, 2'b00, 18'h0);
        idle("R11", 1);
        #2 slp = 1;
        #1 check("R11", dout_en, dout, 1'b0, 18'h0);
        slp = 0;
        #1 check("R11", dout_en, dout, 1'b1, 18'h2468A);
        idle("R11", 2);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = '0;
        for (int i = 0; i < 8; i++) begin ev[i] = 0; ds[i] = '0; ed[i] = '0; end
        t_flow();
        t_pipe();
        t_bytes();
        t_ilv();
        t_desel();
        t_oe();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule